// File: doc/BRIEF.md
# Store-Pair Detector for Register-Mapped Memory Ports

This block sits beside the instruction decoder of a core whose memory is reached through register pairs: each port has an address register and a data register, and the two live in mirror clusters. The decoder hands the block the two instructions it issues together, a lead slot and a trail slot, each with a destination register number and a result value. Register numbers are `REG_W` bits wide. The top bit tells the two kinds apart: 0 means an address register and 1 means a data register. The remaining low bits give the port number.

When the lead slot writes an address register and the trail slot writes the data register of the same port in the same cycle, the pair is read as a store. The block then drives a one-cycle write strobe that carries the port, the address and the data. It requests no cache line and leaves the port idle. An address write without such a partner is taken as a load set-up. The block issues a line-fetch request for that port and marks the port busy. While a port is busy, a read of its data register raises a stall. The stall holds until the memory side reports that the line for that port has arrived. Only one comparator is needed, because the two halves of a pair always sit in the same issue group.

Top module: `storePairDetect`

## Requirements
- R1: After reset, `fetchReq`, `wrValid` and `stall` are 0 and every bit of `portBusy` is 0.
- R2: A valid lead write to address register p (top bit 0), together with a valid trail write to register number p with its top bit set, produces `wrValid`=1 one clock edge later. In that cycle `wrPort`=p's low bits, `wrAddr` is the lead value and `wrData` is the trail value, and `fetchReq` stays 0.
- R3: A recognised pair leaves its port not busy after the same edge, even if the port was busy before.
- R4: A valid lead address write that is not paired produces `fetchReq`=1 one edge later. `fetchPort` is the port and `fetchAddr` is the lead value, and `portBusy` for that port is 1 in the same cycle.
- R5: A trail slot that is invalid, that targets another port, or that is itself an address register breaks the pair, and the lead address write fetches as in R4.
- R6: `fillValid` with `fillPort`=p clears `portBusy[p]` at the next edge and leaves all other ports unchanged.
- R7: `stall` is 1 in the same cycle that `rdValid` names a data register (top bit 1) of a busy port. It is 0 for reads of address registers and for reads of idle ports.
- R8: A lead write to a data register, or any trail write without a qualifying lead, produces neither strobe and changes no busy flag.
- R9: If a fetch and a fill hit the same port in the same cycle, the port stays busy.
- R10: `fetchReq` and `wrValid` are single-cycle pulses and are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| leadValid | input | 1 | Lead slot writes a register |
| leadDest | input | REG_W | Lead destination register number |
| leadValue | input | DATA_W | Lead result value |
| trailValid | input | 1 | Trail slot writes a register |
| trailDest | input | REG_W | Trail destination register number |
| trailValue | input | DATA_W | Trail result value |
| rdValid | input | 1 | A decoded instruction reads a register |
| rdDest | input | REG_W | Register number being read |
| fillValid | input | 1 | A line has arrived for a port |
| fillPort | input | REG_W-1 | Port whose line arrived |
| fetchReq | output | 1 | Line-fetch request strobe |
| fetchPort | output | REG_W-1 | Port of the fetch request |
| fetchAddr | output | DATA_W | Address to fetch |
| wrValid | output | 1 | Store strobe |
| wrPort | output | REG_W-1 | Port of the store |
| wrAddr | output | DATA_W | Store address |
| wrData | output | DATA_W | Store data |
| portBusy | output | 2**(REG_W-1) | Per-port line-pending flags |
| stall | output | 1 | Decode stall for a read of a pending data register |

## Verification
Each slot stimulus is registered once, so the store strobe, the fetch request and the busy flags all change on the first rising edge after the inputs are applied. The bench drives inputs at a falling edge and samples these outputs one time unit after the following rising edge. Fill handling also takes exactly one edge, so the busy flags are checked at that same point. `stall` is combinational from `rdValid`, `rdDest` and the registered busy flags, so it is sampled in the same half cycle in which the read is driven, with no edge in between.

// File: rtl/storePairPkg.sv
package storePairPkg;
  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic pairHit;   // lead address write + trail data write, same port
    logic fetchHit;  // lead address write with no partner
  } pairStrobes_t;
endpackage

// File: rtl/storePairCtrl.sv
module storePairCtrl
  import storePairPkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    leadValid,
  input  logic [REG_W-1:0]        leadDest,
  input  logic                    trailValid,
  input  logic [REG_W-1:0]        trailDest,
  input  logic                    rdValid,
  input  logic [REG_W-1:0]        rdDest,
  input  logic                    fillValid,
  input  logic [REG_W-2:0]        fillPort,
  output pairStrobes_t            strobes,
  output logic [REG_W-2:0]        hitPort,
  output logic                    fetchReq,
  output logic                    wrValid,
  output logic [REG_W-2:0]        outPort,
  output logic [2**(REG_W-1)-1:0] portBusy,
  output logic                    stall
);
  localparam int SEL    = REG_W - 1;
  localparam int PORT_W = REG_W - 1;
  localparam int PORTS  = 2 ** PORT_W;

  logic             leadIsAddr;
  logic [REG_W-1:0] partnerDest;
  logic [PORT_W-1:0] rdPort;

  always_comb begin
    leadIsAddr       = leadValid && !leadDest[SEL];
    partnerDest      = {~leadDest[SEL], leadDest[SEL-1:0]};
    strobes.pairHit  = leadIsAddr && trailValid && (trailDest == partnerDest);
    strobes.fetchHit = leadIsAddr && !strobes.pairHit;
    hitPort          = leadDest[PORT_W-1:0];
    rdPort           = rdDest[PORT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchReq <= 1'b0;
      wrValid  <= 1'b0;
      outPort  <= '0;
    end else begin
      fetchReq <= strobes.fetchHit;
      wrValid  <= strobes.pairHit;
      if (strobes.fetchHit || strobes.pairHit) outPort <= hitPort;
    end
  end

  // One pending flag per port; a new fetch wins over a fill or a store.
  for (genvar p = 0; p < PORTS; p++) begin : g_busy
    logic setMe, clrMe;
    always_comb begin
      setMe = strobes.fetchHit && (hitPort == PORT_W'(p));
      clrMe = (strobes.pairHit && (hitPort == PORT_W'(p))) ||
              (fillValid && (fillPort == PORT_W'(p)));
    end
    always_ff @(posedge clk) begin
      if (!rstN)      portBusy[p] <= 1'b0;
      else if (setMe) portBusy[p] <= 1'b1;
      else if (clrMe) portBusy[p] <= 1'b0;
    end
  end

  always_comb stall = rdValid && rdDest[SEL] && portBusy[rdPort];
endmodule

// File: rtl/storePairPath.sv
module storePairPath
  import storePairPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pairStrobes_t      strobes,
  input  logic [DATA_W-1:0] leadValue,
  input  logic [DATA_W-1:0] trailValue,
  output logic [DATA_W-1:0] fetchAddr,
  output logic [DATA_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchAddr <= '0;
      wrAddr    <= '0;
      wrData    <= '0;
    end else begin
      if (strobes.fetchHit) fetchAddr <= leadValue;
      if (strobes.pairHit) begin
        wrAddr <= leadValue;
        wrData <= trailValue;
      end
    end
  end
endmodule

// File: rtl/storePairDetect.sv
module storePairDetect
  import storePairPkg::*;
#(
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    leadValid,
  input  logic [REG_W-1:0]        leadDest,
  input  logic [DATA_W-1:0]       leadValue,
  input  logic                    trailValid,
  input  logic [REG_W-1:0]        trailDest,
  input  logic [DATA_W-1:0]       trailValue,
  input  logic                    rdValid,
  input  logic [REG_W-1:0]        rdDest,
  input  logic                    fillValid,
  input  logic [REG_W-2:0]        fillPort,
  output logic                    fetchReq,
  output logic [REG_W-2:0]        fetchPort,
  output logic [DATA_W-1:0]       fetchAddr,
  output logic                    wrValid,
  output logic [REG_W-2:0]        wrPort,
  output logic [DATA_W-1:0]       wrAddr,
  output logic [DATA_W-1:0]       wrData,
  output logic [2**(REG_W-1)-1:0] portBusy,
  output logic                    stall
);
  pairStrobes_t     strobes;
  logic [REG_W-2:0] hitPort;
  logic [REG_W-2:0] outPort;

  storePairCtrl #(.REG_W(REG_W)) ctrl (
    .clk(clk), .rstN(rstN),
    .leadValid(leadValid), .leadDest(leadDest),
    .trailValid(trailValid), .trailDest(trailDest),
    .rdValid(rdValid), .rdDest(rdDest),
    .fillValid(fillValid), .fillPort(fillPort),
    .strobes(strobes), .hitPort(hitPort),
    .fetchReq(fetchReq), .wrValid(wrValid), .outPort(outPort),
    .portBusy(portBusy), .stall(stall)
  );

  storePairPath #(.DATA_W(DATA_W)) path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .leadValue(leadValue), .trailValue(trailValue),
    .fetchAddr(fetchAddr), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign fetchPort = outPort;
  assign wrPort    = outPort;
endmodule

// File: rtl/storePairChecks.sv
module storePairChecks #(
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    leadValid,
  input logic [REG_W-1:0]        leadDest,
  input logic [DATA_W-1:0]       leadValue,
  input logic                    trailValid,
  input logic [REG_W-1:0]        trailDest,
  input logic [DATA_W-1:0]       trailValue,
  input logic                    rdValid,
  input logic [REG_W-1:0]        rdDest,
  input logic                    fillValid,
  input logic [REG_W-2:0]        fillPort,
  input logic                    fetchReq,
  input logic [REG_W-2:0]        fetchPort,
  input logic [DATA_W-1:0]       fetchAddr,
  input logic                    wrValid,
  input logic [REG_W-2:0]        wrPort,
  input logic [DATA_W-1:0]       wrAddr,
  input logic [DATA_W-1:0]       wrData,
  input logic [2**(REG_W-1)-1:0] portBusy,
  input logic                    stall
);
  localparam int SEL = REG_W - 1;

  logic pairSeen;
  always_comb pairSeen = leadValid && !leadDest[SEL] && trailValid && trailDest[SEL] &&
                         (trailDest[SEL-1:0] == leadDest[SEL-1:0]);

  // R2
  pair_to_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairSeen |=> wrValid && !fetchReq && (wrAddr == $past(leadValue)) && (wrData == $past(trailValue)));

  // R3
  store_port_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !portBusy[wrPort]);

  // R4
  fetch_marks_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> portBusy[fetchPort]);

  // R8
  no_lead_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !leadValid |=> !fetchReq && !wrValid);

  // R7
  stall_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> rdValid && rdDest[SEL]);

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchReq && wrValid));
endmodule

bind storePairDetect storePairChecks #(.REG_W(REG_W), .DATA_W(DATA_W)) chk (.*);

// File: tb/storePairDetect_test.sv
module storePairDetect_test;
  localparam int REG_W  = 4;
  localparam int DATA_W = 32;
  localparam int PORTS  = 2 ** (REG_W - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic leadValid = 1'b0, trailValid = 1'b0, rdValid = 1'b0, fillValid = 1'b0;
  logic [REG_W-1:0] leadDest = '0, trailDest = '0, rdDest = '0;
  logic [DATA_W-1:0] leadValue = '0, trailValue = '0;
  logic [REG_W-2:0] fillPort = '0;
  logic fetchReq, wrValid, stall;
  logic [REG_W-2:0] fetchPort, wrPort;
  logic [DATA_W-1:0] fetchAddr, wrAddr, wrData;
  logic [PORTS-1:0] portBusy;

  int total = 0;
  int bad = 0;
  logic [PORTS-1:0] expBusy = '0;

  always #5 clk = ~clk;

  storePairDetect #(.REG_W(REG_W), .DATA_W(DATA_W)) uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one issue group at a falling edge, step one rising edge, sample 1 unit later.
  task automatic issue(input logic lv, input logic [REG_W-1:0] ld, input logic [DATA_W-1:0] lval,
                       input logic tv, input logic [REG_W-1:0] td, input logic [DATA_W-1:0] tval,
                       input logic fv, input logic [REG_W-2:0] fp);
    @(negedge clk);
    leadValid = lv; leadDest = ld; leadValue = lval;
    trailValid = tv; trailDest = td; trailValue = tval;
    fillValid = fv; fillPort = fp;
    @(posedge clk); #1;
    leadValid = 1'b0; trailValid = 1'b0; fillValid = 1'b0;
  endtask

  task automatic idleCycle();
    issue(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic readProbe(input logic [REG_W-1:0] rd, input logic exp, input string req);
    @(negedge clk);
    rdValid = 1'b1; rdDest = rd;
    #1 check(req, 64'(stall), 64'(exp));
    rdValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 fetchReq", 64'(fetchReq), 0);
    check("R1 wrValid", 64'(wrValid), 0);
    check("R1 portBusy", 64'(portBusy), 0);
    check("R1 stall", 64'(stall), 0);
  endtask

  task automatic testPair();
    issue(1'b1, 4'h5, 32'h1234_5678, 1'b1, 4'hD, 32'hBEEF_0001, 1'b0, '0);
    check("R2 wrValid", 64'(wrValid), 1);
    check("R2 wrPort", 64'(wrPort), 5);
    check("R2 wrAddr", 64'(wrAddr), 64'h1234_5678);
    check("R2 wrData", 64'(wrData), 64'hBEEF_0001);
    check("R2 no fetch", 64'(fetchReq), 0);
    check("R3 port5 idle", 64'(portBusy), 64'(expBusy));
    idleCycle();
    check("R10 store pulse", 64'(wrValid), 0);
  endtask

  task automatic testFetch();
    issue(1'b1, 4'h2, 32'h0000_0040, 1'b0, 4'hA, 32'h0, 1'b0, '0);
    expBusy[2] = 1'b1;
    check("R4 fetchReq", 64'(fetchReq), 1);
    check("R4 fetchPort", 64'(fetchPort), 2);
    check("R4 fetchAddr", 64'(fetchAddr), 64'h40);
    check("R4 busy", 64'(portBusy), 64'(expBusy));
    check("R10 exclusive", 64'(wrValid), 0);
    idleCycle();
    check("R10 fetch pulse", 64'(fetchReq), 0);
  endtask

  task automatic testStall();
    readProbe(4'hA, 1'b1, "R7 busy data read");
    readProbe(4'h2, 1'b0, "R7 address read");
    readProbe(4'hB, 1'b0, "R7 idle port read");
  endtask

  task automatic testMismatch();
    issue(1'b1, 4'h3, 32'h300, 1'b1, 4'hC, 32'h1, 1'b0, '0);
    expBusy[3] = 1'b1;
    check("R5 other port fetch", 64'(fetchReq), 1);
    check("R5 other port id", 64'(fetchPort), 3);
    check("R5 other port no store", 64'(wrValid), 0);
    issue(1'b1, 4'h4, 32'h400, 1'b1, 4'h4, 32'h2, 1'b0, '0);
    expBusy[4] = 1'b1;
    check("R5 trail address fetch", 64'(fetchReq), 1);
    check("R5 trail address no store", 64'(wrValid), 0);
    issue(1'b1, 4'h6, 32'h600, 1'b0, 4'hE, 32'h3, 1'b0, '0);
    expBusy[6] = 1'b1;
    check("R5 trail invalid fetch", 64'(fetchReq), 1);
    check("R5 trail invalid addr", 64'(fetchAddr), 64'h600);
    check("R5 busy set", 64'(portBusy), 64'(expBusy));
  endtask

  task automatic testIgnored();
    issue(1'b1, 4'h9, 32'h900, 1'b1, 4'h1, 32'h4, 1'b0, '0);
    check("R8 data lead no fetch", 64'(fetchReq), 0);
    check("R8 data lead no store", 64'(wrValid), 0);
    check("R8 busy unchanged", 64'(portBusy), 64'(expBusy));
    issue(1'b0, 4'h1, 32'h0, 1'b1, 4'h9, 32'h5, 1'b0, '0);
    check("R8 trail only no strobe", 64'(fetchReq | wrValid), 0);
  endtask

  task automatic testFill();
    issue(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 3'd2);
    expBusy[2] = 1'b0;
    check("R6 fill clears one port", 64'(portBusy), 64'(expBusy));
    readProbe(4'hA, 1'b0, "R7 after fill");
  endtask

  task automatic testPairClears();
    issue(1'b1, 4'h3, 32'hA0A0, 1'b1, 4'hB, 32'h5A5A, 1'b0, '0);
    expBusy[3] = 1'b0;
    check("R3 pair clears busy", 64'(portBusy), 64'(expBusy));
    check("R2 store on busy port", 64'(wrValid), 1);
  endtask

  task automatic testSetWins();
    issue(1'b1, 4'h4, 32'h4444, 1'b0, '0, '0, 1'b1, 3'd4);
    check("R9 fetch beats fill", 64'(portBusy), 64'(expBusy));
    check("R9 fetch issued", 64'(fetchReq), 1);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testPair();
    testFetch();
    testStall();
    testMismatch();
    testIgnored();
    testFill();
    testPairClears();
    testSetWins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule